// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block is the device-side command engine of a byte-wide, NOR-style parallel flash array. Bytes written on a simple write strobe are not stored directly: they are decoded as commands. The engine selects what a read returns (array contents, identifier bytes or the status byte) and runs two-write block-erase and byte-program sequences against an internal cell array. Each operation holds the device busy for a parameterised number of clock cycles.

Each status byte carries a ready flag and two sticky failure flags. Two injection inputs let a test environment force an erase or program failure at the end of an operation. A failed operation leaves the array unchanged. The read path is combinational from the address, so a host sees the result of an address change in the same cycle. The block size is `2**BLK_W` bytes: `BLK_W=16` gives 64 KiB blocks, and the defaults shrink it for simulation.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, the device is in array-read mode and ready, with both failure flags clear, and every array byte reads 0xFF.
- R2: After command 0x90, a read at offset 0 returns `MFR_CODE`, a read at offset `DEV_CODE_OFS` returns `DEV_CODE`, and any other offset returns 0x00.
- R3: Command 0xFF makes reads return the array byte at the read address.
- R4: After command 0x70, a read at any address returns the status byte. In that byte, bit 7 is ready, bit 5 is erase failure, bit 4 is program failure, and the other bits are 0.
- R5: Writing 0x40 and then a data byte at address A makes the device busy for exactly `PROG_CYCLES` cycles. After that, the byte at A holds its old value ANDed with the data.
- R6: Writing 0x20 and then 0xD0 erases the block holding the address of the 0xD0 write (address bits above `BLK_W`). The device is busy for exactly `ERASE_CYCLES` cycles, then every byte of that block reads 0xFF. Other blocks are left unchanged.
- R7: While busy, ready reads 0 and any read returns the status byte. Writes made while busy are ignored.
- R8: Once 0x20 or 0x40 has been written, and after every operation ends, reads return the status byte until a mode command arrives.
- R9: If `inj_prog_fail` or `inj_erase_fail` is high in the last busy cycle, the operation sets bit 4 or bit 5 respectively, and the array is left unchanged.
- R10: The failure flags stay set across later commands and successful operations until command 0x50 clears both. Command 0x50 does not change the read mode.
- R11: A second write after 0x20 other than 0xD0 aborts the erase. It sets both failure flags, does not make the device busy, and leaves the array unchanged.
- R12: A command byte outside the recognised set leaves the read mode and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Command or data byte |
| inj_prog_fail | input | 1 | Force the current program to fail |
| inj_erase_fail | input | 1 | Force the current erase to fail |
| rdata | output | 8 | Read data selected by the current mode |
| ready | output | 1 | High when no operation is in progress |

## Verification
The bench builds the block with 8 address bits and 64-byte blocks, which gives four blocks. This makes it cheap to show that an erase stays inside its own block, and lets the model compare all 256 bytes. Erase lasts 20 cycles and program lasts 5, so both busy windows are short enough to count exactly and to be hit with stray writes. The device identifier is placed at offset 2, so that offset 1 must read as zero.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY,
        MODE_IDENT,
        MODE_STATUS
    } rd_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT_CONFIRM,
        PH_WAIT_DATA,
        PH_ERASING,
        PH_PROGRAMMING
    } phase_e;

    localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
    localparam logic [7:0] OP_IDENT      = 8'h90;
    localparam logic [7:0] OP_CLEAR_ERR  = 8'h50;
    localparam logic [7:0] OP_STATUS     = 8'h70;
    localparam logic [7:0] OP_ERASE      = 8'h20;
    localparam logic [7:0] OP_CONFIRM    = 8'hD0;
    localparam logic [7:0] OP_PROGRAM    = 8'h40;

    localparam int SB_READY     = 7;
    localparam int SB_ERASE_ERR = 5;
    localparam int SB_PROG_ERR  = 4;

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = load_val;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done = tmr_q.run && (tmr_q.cnt == '0);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done); // R5

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    erase_go,
    input  logic [ADDR_W-BLK_W-1:0] erase_blk,
    input  logic                    prog_go,
    input  logic [ADDR_W-1:0]       prog_addr,
    input  logic [7:0]              prog_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [7:0]              rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic [ADDR_W-1:0] ia;
            ia = ADDR_W'(i);
            mem_d[i] = mem_q[i];
            if (erase_go && (ia[ADDR_W-1:BLK_W] == erase_blk)) begin
                mem_d[i] = 8'hFF;
            end else if (prog_go && (ia == prog_addr)) begin
                mem_d[i] = mem_q[i] & prog_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'hFF;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

    AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> (mem_q[{$past(erase_blk), BLK_W'(0)}] == 8'hFF)); // R6

    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_go && !erase_go) |=> ((mem_q[$past(prog_addr)] & ~$past(prog_data)) == 8'h00)); // R5

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W       = 8,
    parameter int         BLK_W        = 6,
    parameter int         ERASE_CYCLES = 40,
    parameter int         PROG_CYCLES  = 6,
    parameter logic [7:0] MFR_CODE     = 8'h89,
    parameter logic [7:0] DEV_CODE     = 8'hA6,
    parameter int         DEV_CODE_OFS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              inj_prog_fail,
    input  logic              inj_erase_fail,
    output logic [7:0]        rdata,
    output logic              ready
);
    localparam int BLKIDX_W = ADDR_W - BLK_W;
    localparam int MAX_CYC  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
    localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [ADDR_W-1:0] DEV_ADDR  = ADDR_W'(DEV_CODE_OFS);

    typedef struct packed {
        phase_e              phase;
        rd_mode_e            mode;
        logic                erase_err;
        logic                prog_err;
        logic [BLKIDX_W-1:0] op_blk;
        logic [ADDR_W-1:0]   op_addr;
        logic [7:0]          op_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             tmr_start;
    logic [CNT_W-1:0] tmr_load;
    logic             tmr_done;
    logic             erase_go;
    logic             prog_go;
    logic [7:0]       arr_rd;
    logic [7:0]       status_byte;
    logic [7:0]       ident_byte;
    logic             busy;

    always_comb begin
        ctl_d     = ctl_q;
        tmr_start = 1'b0;
        tmr_load  = '0;
        erase_go  = 1'b0;
        prog_go   = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (wr_en) begin
                    case (wdata)
                        OP_READ_ARRAY: ctl_d.mode = MODE_ARRAY;
                        OP_IDENT:      ctl_d.mode = MODE_IDENT;
                        OP_STATUS:     ctl_d.mode = MODE_STATUS;
                        OP_CLEAR_ERR: begin
                            ctl_d.erase_err = 1'b0;
                            ctl_d.prog_err  = 1'b0;
                        end
                        OP_ERASE: begin
                            ctl_d.phase = PH_WAIT_CONFIRM;
                            ctl_d.mode  = MODE_STATUS;
                        end
                        OP_PROGRAM: begin
                            ctl_d.phase = PH_WAIT_DATA;
                            ctl_d.mode  = MODE_STATUS;
                        end
                        default: ;
                    endcase
                end
            end
            PH_WAIT_CONFIRM: begin
                if (wr_en) begin
                    if (wdata == OP_CONFIRM) begin
                        ctl_d.phase  = PH_ERASING;
                        ctl_d.op_blk = addr[ADDR_W-1:BLK_W];
                        tmr_start    = 1'b1;
                        tmr_load     = ERASE_LOAD;
                    end else begin
                        ctl_d.phase     = PH_IDLE;
                        ctl_d.erase_err = 1'b1;
                        ctl_d.prog_err  = 1'b1;
                    end
                end
            end
            PH_WAIT_DATA: begin
                if (wr_en) begin
                    ctl_d.phase   = PH_PROGRAMMING;
                    ctl_d.op_addr = addr;
                    ctl_d.op_data = wdata;
                    tmr_start     = 1'b1;
                    tmr_load      = PROG_LOAD;
                end
            end
            PH_ERASING: begin
                if (tmr_done) begin
                    ctl_d.phase = PH_IDLE;
                    if (inj_erase_fail) begin
                        ctl_d.erase_err = 1'b1;
                    end else begin
                        erase_go = 1'b1;
                    end
                end
            end
            PH_PROGRAMMING: begin
                if (tmr_done) begin
                    ctl_d.phase = PH_IDLE;
                    if (inj_prog_fail) begin
                        ctl_d.prog_err = 1'b1;
                    end else begin
                        prog_go = 1'b1;
                    end
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.phase <= PH_IDLE;
            ctl_q.mode  <= MODE_ARRAY;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    flash_busy_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tmr_start),
        .load_val (tmr_load),
        .done     (tmr_done)
    );

    flash_cell_array #(
        .ADDR_W (ADDR_W),
        .BLK_W  (BLK_W)
    ) array_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_go  (erase_go),
        .erase_blk (ctl_q.op_blk),
        .prog_go   (prog_go),
        .prog_addr (ctl_q.op_addr),
        .prog_data (ctl_q.op_data),
        .rd_addr   (addr),
        .rd_data   (arr_rd)
    );

    always_comb begin
        busy        = (ctl_q.phase == PH_ERASING) || (ctl_q.phase == PH_PROGRAMMING);
        status_byte = 8'h00;
        status_byte[SB_READY]     = !busy;
        status_byte[SB_ERASE_ERR] = ctl_q.erase_err;
        status_byte[SB_PROG_ERR]  = ctl_q.prog_err;
        if (addr == '0) begin
            ident_byte = MFR_CODE;
        end else if (addr == DEV_ADDR) begin
            ident_byte = DEV_CODE;
        end else begin
            ident_byte = 8'h00;
        end
        if (busy || (ctl_q.mode == MODE_STATUS)) begin
            rdata = status_byte;
        end else if (ctl_q.mode == MODE_IDENT) begin
            rdata = ident_byte;
        end else begin
            rdata = arr_rd;
        end
    end

    assign ready = !busy;

    AST_READY_AFTER_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(tmr_done)); // R5

    AST_BUSY_READS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (rdata[7] == 1'b0)); // R7

    AST_BAD_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.phase == PH_WAIT_CONFIRM) && wr_en && (wdata != OP_CONFIRM))
        |=> (ready && ctl_q.erase_err && ctl_q.prog_err)); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.prog_err && !(wr_en && (ctl_q.phase == PH_IDLE) && (wdata == OP_CLEAR_ERR)))
        |=> ctl_q.prog_err); // R10

    AST_DATA_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.phase == PH_WAIT_DATA) && wr_en) |=> !ready); // R5

endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;
    localparam int ADDR_W = 8;
    localparam int BLK_W  = 6;
    localparam int ECYC   = 20;
    localparam int PCYC   = 5;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam logic [7:0] MFR = 8'h89;
    localparam logic [7:0] DEV = 8'hA6;
    localparam int DOFS   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic              inj_prog_fail = 1'b0;
    logic              inj_erase_fail = 1'b0;
    logic [7:0]        rdata;
    logic              ready;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    flash_cmd_ctrl #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .ERASE_CYCLES(ECYC), .PROG_CYCLES(PCYC),
        .MFR_CODE(MFR), .DEV_CODE(DEV), .DEV_CODE_OFS(DOFS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .inj_prog_fail(inj_prog_fail), .inj_erase_fail(inj_erase_fail),
        .rdata(rdata), .ready(ready)
    );

    // reference model: 0 array, 1 ident, 2 status; pend 0 none, 1 await confirm, 2 await data
    int m_mem [DEPTH];
    int m_mode, m_pend, m_left, m_kind, m_tgt, m_dat;
    bit m_ee, m_pe;

    function automatic int m_status();
        return ((m_left > 0) ? 0 : 8'h80) | (m_ee ? 8'h20 : 0) | (m_pe ? 8'h10 : 0);
    endfunction

    function automatic int m_read(int a);
        if (m_left > 0 || m_mode == 2) return m_status();
        if (m_mode == 1) return (a == 0) ? MFR : ((a == DOFS) ? DEV : 0);
        return m_mem[a];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
            m_mode = 0; m_pend = 0; m_left = 0; m_ee = 0; m_pe = 0;
        end else if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
                if (m_kind == 1) begin
                    if (inj_erase_fail) m_ee = 1;
                    else for (int i = 0; i < (1 << BLK_W); i++) m_mem[m_tgt * (1 << BLK_W) + i] = 8'hFF;
                end else begin
                    if (inj_prog_fail) m_pe = 1;
                    else m_mem[m_tgt] = m_mem[m_tgt] & m_dat;
                end
            end
        end else if (wr_en) begin
            if (m_pend == 1) begin
                m_pend = 0;
                if (wdata == 8'hD0) begin m_kind = 1; m_tgt = int'(addr) >> BLK_W; m_left = ECYC; end
                else begin m_ee = 1; m_pe = 1; end
            end else if (m_pend == 2) begin
                m_pend = 0; m_kind = 2; m_tgt = int'(addr); m_dat = int'(wdata); m_left = PCYC;
            end else if (wdata == 8'hFF) m_mode = 0;
            else if (wdata == 8'h90) m_mode = 1;
            else if (wdata == 8'h70) m_mode = 2;
            else if (wdata == 8'h50) begin m_ee = 0; m_pe = 0; end
            else if (wdata == 8'h20) begin m_pend = 1; m_mode = 2; end
            else if (wdata == 8'h40) begin m_pend = 2; m_mode = 2; end
        end
    end

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            check(cur_req, int'(rdata), m_read(int'(addr)));
            check(cur_req, int'(ready), (m_left > 0) ? 0 : 1);
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(string req, int a, int exp);
        @(negedge clk);
        addr = ADDR_W'(a);
        #4;
        check(req, int'(rdata), exp);
    endtask

    // counts cycles with ready low, sampled away from edges
    task automatic wait_ready(output int busy_n);
        busy_n = 0;
        #4;
        while (!ready && busy_n < 1000) begin
            busy_n++;
            @(negedge clk); #4;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        cur_req = "R1";
        peek("R1", 0, 8'hFF);
        peek("R1", 8'hC5, 8'hFF);
        check("R1", int'(ready), 1);
        // R5 program, busy length, AND behaviour
        cur_req = "R5";
        wr(8'h10, 8'h40);
        @(negedge clk); wr_en = 1'b1; addr = 8'h10; wdata = 8'h5A;
        @(negedge clk); wr_en = 1'b0;
        wait_ready(n);
        check("R5", n, PCYC);
        cur_req = "R8";
        peek("R8", 8'h33, 8'h80);
        cur_req = "R3";
        wr(0, 8'hFF);
        peek("R3", 8'h10, 8'h5A);
        cur_req = "R5";
        wr(0, 8'h40); wr(8'h10, 8'hF0); wait_ready(n);
        wr(0, 8'hFF);
        peek("R5", 8'h10, 8'h50);
        wr(0, 8'h40); wr(8'h45, 8'h3C); wait_ready(n);
        // R2, R12
        cur_req = "R2";
        wr(0, 8'h90);
        peek("R2", 0, MFR);
        peek("R2", DOFS, DEV);
        peek("R2", 1, 8'h00);
        cur_req = "R12";
        wr(0, 8'h33);
        peek("R12", 0, MFR);
        // R6 erase block 0, block 1 untouched
        cur_req = "R6";
        wr(8'h3F, 8'h20);
        @(negedge clk); wr_en = 1'b1; addr = 8'h20; wdata = 8'hD0;
        @(negedge clk); wr_en = 1'b0;
        wait_ready(n);
        check("R6", n, ECYC);
        wr(0, 8'hFF);
        peek("R6", 8'h10, 8'hFF);
        peek("R6", 8'h45, 8'h3C);
        // R7 writes during busy are ignored, reads give status
        cur_req = "R7";
        wr(0, 8'h40); wr(8'h80, 8'h0F);
        peek("R7", 8'h80, 8'h00);
        wr(0, 8'hFF); wr(0, 8'h90); wr(0, 8'h50);
        wait_ready(n);
        peek("R7", 0, 8'h80);
        wr(0, 8'hFF);
        peek("R7", 8'h80, 8'h0F);
        // R9 program failure, R4 status layout, R10 stickiness
        cur_req = "R9";
        inj_prog_fail = 1'b1;
        wr(0, 8'h40); wr(8'h81, 8'h00); wait_ready(n);
        inj_prog_fail = 1'b0;
        peek("R9", 0, 8'h90);
        wr(0, 8'hFF);
        peek("R9", 8'h81, 8'hFF);
        cur_req = "R10";
        wr(0, 8'h40); wr(8'h82, 8'h11); wait_ready(n);
        wr(0, 8'h70);
        peek("R10", 8'h99, 8'h90);
        wr(0, 8'h50);
        peek("R10", 8'h99, 8'h80);
        cur_req = "R4";
        wr(0, 8'hFF); wr(0, 8'h70);
        peek("R4", 8'h5, 8'h80);
        // R9 erase failure leaves block unchanged
        cur_req = "R9";
        inj_erase_fail = 1'b1;
        wr(8'h80, 8'h20); wr(8'h80, 8'hD0); wait_ready(n);
        inj_erase_fail = 1'b0;
        peek("R9", 0, 8'hA0);
        wr(0, 8'hFF);
        peek("R9", 8'h80, 8'h0F);
        wr(0, 8'h50);
        // R11 bad confirm
        cur_req = "R11";
        wr(8'h80, 8'h20); wr(8'h80, 8'h11);
        #4;
        check("R11", int'(ready), 1);
        peek("R11", 8'h80, 8'hB0);
        wr(0, 8'hFF);
        peek("R11", 8'h80, 8'h0F);
        wr(0, 8'h50);
        peek("R10", 8'h80, 8'h0F);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule